// File: doc/BRIEF.md
# Interrupt Status, Mask and General-Purpose Timer

This block collects event pulses from the rest of a network controller into a 16-bit status word. It gates that word with a 16-bit mask and raises one level-sensitive interrupt line whenever a pending status bit is also enabled. Software clears status bits by writing ones to them. Clearing the receive-buffer-exhausted bit also sends a one-cycle request to the receive-resource logic, asking it to fetch its next buffer entry.

The same block contains a 32-bit down-counter that software reads and loads as two 16-bit words. The counter decrements once per tick strobe, which a prescaler supplies at 5 MHz. When the counter runs out, it reloads to all ones and sets the timer-complete status bit. Start and stop bits in a small command register control the counter. That register also holds a reset flag, and while the flag is set, the next command write does nothing except clear it.

Software reaches every register through a word-addressed port. Writes take effect on a clock edge, and reads are combinational. Address map: 0 command, 1 mask, 2 status, 3 timer low word, 4 timer high word. Any other address reads as zero.

Top module: `irqwd_top`

## Requirements
- R1: After reset the command register reads 0x0094 (reset flag bit 7, stop bit 4, receive-disable bit 2). The mask, status and both timer words read 0, and the interrupt output is low.
- R2: A mask write stores bits 14:0 of the written data, and bit 15 always reads 0.
- R3: A status write clears exactly those status bits that are written as 1. Bits written as 0 keep their value.
- R4: A one-cycle pulse on event input bit i sets status bit i on the next clock edge. If an event and a clear for the same bit arrive in the same cycle, the bit stays set.
- R5: The interrupt output is high exactly when (mask AND status) is nonzero, evaluated from the registered values after each edge.
- R6: A status write that clears a set bit 5 raises the fetch request for exactly one cycle, starting on the following edge. Writing 1 to bit 5 when it is already clear raises no request.
- R7: The timer value is {high word, low word}. While the timer is running, each cycle with the tick strobe high lowers the value by one. Cycles without a tick leave it unchanged.
- R8: A tick while the running timer holds 0 reloads both words to 0xFFFF and sets status bit 7 (timer complete) on that same edge.
- R9: When the reset flag is clear, a command write with bit 4 set sets stop and clears start (bit 5), and the count freezes. A write with bit 5 set sets start and clears stop, and counting resumes. If both bits are written together, start wins.
- R10: A write to either timer word loads that word and takes precedence over a tick in the same cycle. The timer keeps running from the new value.
- R11: While the reset flag is set, a command write without bit 7 only clears the flag and ignores the other bits. A command write with bit 7 set sets the reset flag and receive-disable, and leaves start and stop unchanged.
- R12: A read of either timer word returns the count held in the register at that moment, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| evt_i | input | 16 | One-cycle event pulses, bit i sets status bit i |
| tick_i | input | 1 | Timer tick strobe (5 MHz rate) |
| irq_o | output | 1 | Level interrupt request |
| fetch_req_o | output | 1 | One-cycle request to fetch the next receive resource |

## Verification
Every register result (mask, status, command, timer words and the derived interrupt level) becomes visible one clock edge after the write, event or tick that causes it. The fetch request is high only during the cycle after the clearing write. Read data is combinational from the registers. The bench therefore drives each stimulus just after a falling edge and samples on the next falling edge, half a cycle after the rising edge that takes effect. It samples the fetch request in that same window and again one cycle later, to prove that the pulse lasts exactly one cycle.

// File: rtl/irqwd_pkg.sv
package irqwd_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;
    localparam int CNT_W  = 2 * DATA_W;

    // command bit positions
    localparam int CMD_RXOFF = 2;
    localparam int CMD_STOP  = 4;
    localparam int CMD_START = 5;
    localparam int CMD_RST   = 7;

    // status bit positions with a dedicated meaning
    localparam int ST_BUFEX = 5;
    localparam int ST_TDONE = 7;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CMD  = 3'd0,
        SEL_MASK = 3'd1,
        SEL_STAT = 3'd2,
        SEL_TLO  = 3'd3,
        SEL_THI  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic rst;
        logic rxoff;
        logic stop;
        logic start;
    } cmd_st_t;
endpackage

// File: rtl/irqwd_cmd.sv
module irqwd_cmd
    import irqwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cmd_word,
    output logic              run
);
    cmd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            if (st_q.rst && !wdata[CMD_RST]) begin
                st_d.rst = 1'b0;
            end else begin
                if (wdata[CMD_STOP]) begin
                    st_d.stop  = 1'b1;
                    st_d.start = 1'b0;
                end
                if (wdata[CMD_START]) begin
                    st_d.start = 1'b1;
                    st_d.stop  = 1'b0;
                end
                if (wdata[CMD_RXOFF]) st_d.rxoff = 1'b1;
                if (wdata[CMD_RST]) begin
                    st_d.rst   = 1'b1;
                    st_d.rxoff = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{rst: 1'b1, rxoff: 1'b1, stop: 1'b1, start: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cmd_word            = '0;
        cmd_word[CMD_RST]   = st_q.rst;
        cmd_word[CMD_RXOFF] = st_q.rxoff;
        cmd_word[CMD_STOP]  = st_q.stop;
        cmd_word[CMD_START] = st_q.start;
    end

    assign run = !st_q.stop;

    // R9: start and stop never both set
    a_r9_start_stop_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.start && st_q.stop));

    // R11: a write without reset bit while in reset only drops the flag
    a_r11_reset_exit_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && st_q.rst && !wdata[CMD_RST]) |=>
            (!st_q.rst && st_q.stop == $past(st_q.stop) && st_q.start == $past(st_q.start)));
endmodule

// File: rtl/irqwd_timer.sv
module irqwd_timer #(
    parameter int HALF_W = 16,
    localparam int CW    = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wdata,
    output logic [CW-1:0]     count,
    output logic              uflow
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    loading;
    logic    step;

    assign loading = wr_lo || wr_hi;
    assign step    = run && tick && !loading;
    assign uflow   = step && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (loading) begin
            if (wr_lo) st_d.cnt[HALF_W-1:0]  = wdata;
            if (wr_hi) st_d.cnt[CW-1:HALF_W] = wdata;
        end else if (step) begin
            if (st_q.cnt == '0) st_d.cnt = '1;
            else                st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0};
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    // R7: one step per tick
    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !loading && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R8: reload to all ones after running out
    a_r8_reload_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !loading && st_q.cnt == '0) |=> (&st_q.cnt));

    // R9: frozen while stopped
    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !loading) |=> $stable(st_q.cnt));
endmodule

// File: rtl/irqwd_stat.sv
module irqwd_stat #(
    parameter int W         = 16,
    parameter int FETCH_BIT = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_mask,
    input  logic         wr_stat,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] evt,
    output logic [W-1:0] mask,
    output logic [W-1:0] status,
    output logic         irq,
    output logic         fetch_req
);
    typedef struct packed {
        logic [W-1:0] mask;
        logic [W-1:0] status;
        logic         fetch;
    } stat_st_t;

    stat_st_t     st_d, st_q;
    logic [W-1:0] clr;

    always_comb begin
        st_d = st_q;
        clr  = wr_stat ? (wdata & st_q.status) : '0;
        if (wr_mask) st_d.mask = {1'b0, wdata[W-2:0]};
        st_d.status = (st_q.status & ~clr) | evt;
        st_d.fetch  = clr[FETCH_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask      = st_q.mask;
    assign status    = st_q.status;
    assign irq       = |(st_q.mask & st_q.status);
    assign fetch_req = st_q.fetch;

    // R2: a mask write keeps the low bits and drops the top bit
    a_r2_mask_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (st_q.mask == {1'b0, $past(wdata[W-2:0])}));

    // R4: an event always lands in the status word
    a_r4_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((st_q.status & $past(evt)) == $past(evt)));

    // R6: the fetch request is a single-cycle pulse
    a_r6_fetch_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fetch |=> !st_q.fetch);

    // R6: a request only follows a clear of a set bit
    a_r6_fetch_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.fetch) |-> ($past(wr_stat) && $past(st_q.status[FETCH_BIT]) && $past(wdata[FETCH_BIT])));
endmodule

// File: rtl/irqwd_top.sv
module irqwd_top
    import irqwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] evt_i,
    input  logic              tick_i,
    output logic              irq_o,
    output logic              fetch_req_o
);
    logic [DATA_W-1:0] cmd_word, mask, status, evt_all;
    logic [CNT_W-1:0]  count;
    logic              run, uflow;
    logic              wr_cmd, wr_mask, wr_stat, wr_lo, wr_hi;

    assign wr_cmd  = reg_wr && (reg_addr == SEL_CMD);
    assign wr_mask = reg_wr && (reg_addr == SEL_MASK);
    assign wr_stat = reg_wr && (reg_addr == SEL_STAT);
    assign wr_lo   = reg_wr && (reg_addr == SEL_TLO);
    assign wr_hi   = reg_wr && (reg_addr == SEL_THI);

    always_comb begin
        evt_all           = evt_i;
        evt_all[ST_TDONE] = evt_i[ST_TDONE] | uflow;
    end

    irqwd_cmd u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_cmd),
        .wdata    (reg_wdata),
        .cmd_word (cmd_word),
        .run      (run)
    );

    irqwd_timer #(.HALF_W(DATA_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick_i),
        .wr_lo (wr_lo),
        .wr_hi (wr_hi),
        .wdata (reg_wdata),
        .count (count),
        .uflow (uflow)
    );

    irqwd_stat #(.W(DATA_W), .FETCH_BIT(ST_BUFEX)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mask   (wr_mask),
        .wr_stat   (wr_stat),
        .wdata     (reg_wdata),
        .evt       (evt_all),
        .mask      (mask),
        .status    (status),
        .irq       (irq_o),
        .fetch_req (fetch_req_o)
    );

    always_comb begin
        unique case (reg_addr)
            SEL_CMD:  reg_rdata = cmd_word;
            SEL_MASK: reg_rdata = mask;
            SEL_STAT: reg_rdata = status;
            SEL_TLO:  reg_rdata = count[DATA_W-1:0];
            SEL_THI:  reg_rdata = count[CNT_W-1:DATA_W];
            default:  reg_rdata = '0;
        endcase
    end

    // R8: running out flags timer-complete
    a_r8_tdone_flag: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> status[ST_TDONE]);

    // R5: interrupt follows enabled pending bits
    a_r5_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask & status) == '0) |-> !irq_o);
endmodule

// File: tb/sim_irqwd_top.sv
module sim_irqwd_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic [15:0] evt_i = 16'h0;
    logic        tick_i = 1'b0;
    logic        irq_o, fetch_req_o;

    int n_run = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    irqwd_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i),
        .tick_i(tick_i), .irq_o(irq_o), .fetch_req_o(fetch_req_o)
    );

    // {write addr, write data, read addr, expected}
    localparam logic [37:0] VEC [6] = '{
        {3'd1, 16'hFFFF, 3'd1, 16'h7FFF},
        {3'd1, 16'h8001, 3'd1, 16'h0001},
        {3'd1, 16'h1234, 3'd1, 16'h1234},
        {3'd3, 16'hBEEF, 3'd3, 16'hBEEF},
        {3'd4, 16'h1234, 3'd4, 16'h1234},
        {3'd4, 16'h0000, 3'd3, 16'hBEEF}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one cycle with given stimulus, returns at the following falling edge
    task automatic cyc(input logic wr, input logic [2:0] a, input logic [15:0] d,
                       input logic [15:0] ev, input logic tk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; evt_i = ev; tick_i = tk;
        @(negedge clk);
        reg_wr = 1'b0; evt_i = 16'h0; tick_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd(3'd0, v); check("R1 cmd", {16'h0, v}, 32'h0094);
        rd(3'd1, v); check("R1 mask", {16'h0, v}, 32'h0);
        rd(3'd2, v); check("R1 status", {16'h0, v}, 32'h0);
        rd(3'd3, v); check("R1 timer lo", {16'h0, v}, 32'h0);
        check("R1 irq", {31'h0, irq_o}, 32'h0);

        foreach (VEC[i]) begin
            cyc(1'b1, VEC[i][37:35], VEC[i][34:19], 16'h0, 1'b0);
            rd(VEC[i][18:16], v);
            check("R2/R10 vector", {16'h0, v}, {16'h0, VEC[i][15:0]});
        end

        cyc(1'b1, 3'd1, 16'h0001, 16'h0, 1'b0);
        cyc(1'b0, 3'd0, 16'h0, 16'h0021, 1'b0);
        rd(3'd2, v); check("R4 event set", {16'h0, v}, 32'h0021);
        check("R5 irq high", {31'h0, irq_o}, 32'h1);
        cyc(1'b1, 3'd2, 16'h0001, 16'h0, 1'b0);
        rd(3'd2, v); check("R3 partial clear", {16'h0, v}, 32'h0020);
        check("R5 irq low", {31'h0, irq_o}, 32'h0);
        check("R6 no fetch", {31'h0, fetch_req_o}, 32'h0);
        cyc(1'b1, 3'd2, 16'h0020, 16'h0, 1'b0);
        check("R6 fetch pulse", {31'h0, fetch_req_o}, 32'h1);
        rd(3'd2, v); check("R3 bit5 clear", {16'h0, v}, 32'h0);
        cyc(1'b0, 3'd0, 16'h0, 16'h0, 1'b0);
        check("R6 fetch one cycle", {31'h0, fetch_req_o}, 32'h0);
        cyc(1'b1, 3'd2, 16'h0020, 16'h0, 1'b0);
        check("R6 no fetch when clear", {31'h0, fetch_req_o}, 32'h0);

        cyc(1'b0, 3'd0, 16'h0, 16'h0004, 1'b0);
        cyc(1'b1, 3'd2, 16'h0004, 16'h0004, 1'b0);
        rd(3'd2, v); check("R4 event beats clear", {16'h0, v}, 32'h0004);
        cyc(1'b1, 3'd2, 16'hFFFF, 16'h0, 1'b0);
        rd(3'd2, v); check("R3 clear all", {16'h0, v}, 32'h0);

        cyc(1'b1, 3'd0, 16'h0020, 16'h0, 1'b0);
        rd(3'd0, v); check("R11 leave reset only", {16'h0, v}, 32'h0014);
        cyc(1'b1, 3'd3, 16'h0005, 16'h0, 1'b0);
        cyc(1'b1, 3'd4, 16'h0000, 16'h0, 1'b0);
        for (int k = 0; k < 3; k++) cyc(1'b0, 3'd0, 16'h0, 16'h0, 1'b1);
        rd(3'd3, v); check("R9 frozen when stopped", {16'h0, v}, 32'h0005);
        cyc(1'b1, 3'd0, 16'h0020, 16'h0, 1'b0);
        rd(3'd0, v); check("R9 start", {16'h0, v}, 32'h0024);
        for (int k = 0; k < 3; k++) cyc(1'b0, 3'd0, 16'h0, 16'h0, 1'b1);
        rd(3'd3, v); check("R7 three ticks", {16'h0, v}, 32'h0002);
        for (int k = 0; k < 4; k++) cyc(1'b0, 3'd0, 16'h0, 16'h0, 1'b0);
        rd(3'd3, v); check("R7 no tick no change", {16'h0, v}, 32'h0002);
        for (int k = 0; k < 2; k++) cyc(1'b0, 3'd0, 16'h0, 16'h0, 1'b1);
        rd(3'd3, v); check("R7 reach zero", {16'h0, v}, 32'h0000);
        rd(3'd2, v); check("R8 no flag before underflow", {16'h0, v}, 32'h0);
        cyc(1'b0, 3'd0, 16'h0, 16'h0, 1'b1);
        rd(3'd3, v); check("R8 reload lo", {16'h0, v}, 32'hFFFF);
        rd(3'd4, v); check("R8 reload hi", {16'h0, v}, 32'hFFFF);
        rd(3'd2, v); check("R8 timer-complete flag", {16'h0, v}, 32'h0080);
        cyc(1'b1, 3'd1, 16'h0080, 16'h0, 1'b0);
        check("R5 irq from timer", {31'h0, irq_o}, 32'h1);

        cyc(1'b1, 3'd3, 16'h0010, 16'h0, 1'b1);
        rd(3'd3, v); check("R10 load beats tick", {16'h0, v}, 32'h0010);
        rd(3'd4, v); check("R10 other word kept", {16'h0, v}, 32'hFFFF);
        cyc(1'b0, 3'd0, 16'h0, 16'h0, 1'b1);
        rd(3'd3, v); check("R12 live count", {16'h0, v}, 32'h000F);
        cyc(1'b1, 3'd0, 16'h0010, 16'h0, 1'b0);
        rd(3'd0, v); check("R9 stop", {16'h0, v}, 32'h0014);
        cyc(1'b0, 3'd0, 16'h0, 16'h0, 1'b1);
        rd(3'd3, v); check("R9 stopped tick ignored", {16'h0, v}, 32'h000F);
        cyc(1'b1, 3'd0, 16'h0030, 16'h0, 1'b0);
        rd(3'd0, v); check("R9 both start wins", {16'h0, v}, 32'h0024);
        cyc(1'b0, 3'd0, 16'h0, 16'h0, 1'b1);
        rd(3'd3, v); check("R9 resumed", {16'h0, v}, 32'h000E);
        cyc(1'b1, 3'd0, 16'h0080, 16'h0, 1'b0);
        rd(3'd0, v); check("R11 enter reset", {16'h0, v}, 32'h00A4);
        cyc(1'b1, 3'd0, 16'h0010, 16'h0, 1'b0);
        rd(3'd0, v); check("R11 stop ignored in reset", {16'h0, v}, 32'h0024);

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule